// File: doc/BRIEF.md
# Receive Frame Filter and Ring Writer

This block sits behind a network receive path. It takes one incoming frame as a byte stream and checks the frame's destination address against a set of acceptance rules: accept everything, broadcast, group (multicast) and the block's own station address. Frames that pass the check are stored in a circular buffer in an external byte memory. The buffer is divided into 256-byte pages and is bounded by a start page and a stop page. A boundary page held by the consumer marks how far stored data has been read, and a frame is accepted only when enough free space remains ahead of the current write page.

Each stored frame begins with a four-byte header at the start of its first page. The header holds the receive status, the page where the next frame will start, and the stored length. Short frames are padded with zeros, and payload that runs past the stop page continues at the start page. When a frame is complete, the block moves its current write page to the next free page, updates the receive status and pulses a receive event that feeds the interrupt status logic. Bytes 6 and onward of an accepted frame are written as they arrive. The six destination bytes, any padding and the header are written after the last byte. During those cycles `in_ready` is low.

Top module: `rx_ring_writer`

## Requirements
- R1: When `cfg_promisc` is 1, every frame is accepted, whatever its destination.
- R2: A destination of six 0xFF bytes is broadcast and is accepted only when `cfg_take_bcast` is 1. Any other destination whose first byte has bit 0 set is a group address and is accepted only when `cfg_take_mcast` is 1.
- R3: Any other destination is accepted only when it equals `cfg_station`, where bits 7:0 hold the first byte received. A rejected frame is consumed with `in_ready` held high, and it causes no `mem_we`, no `rx_event` and no change to `cur_pg`.
- R4: A frame whose first byte arrives while `cfg_halt` is 1 is dropped, in the same way as in R3.
- R5: Free space, in bytes, is (bound−cur)·256 when `cur_pg` is below `cfg_bound_pg`. Otherwise it is (stop−start−(cur−bound))·256. If the free space is less than MAX_FRAME+4 at the frame's first byte, the frame is dropped.
- R6: A frame shorter than 60 bytes is stored padded with zero bytes up to 60. When a frame has fewer than 6 bytes, the filter treats the missing destination bytes as zero.
- R7: The header is written at cur·256+0..3 and holds, in this order: status, next page, T[7:0], T[15:8]. T is the stored length plus 4. Payload byte k is written at cur·256+4+k.
- R8: The next page is cur + floor((T+4+255)/256). If that value is at or above the stop page, (stop−start) is subtracted from it.
- R9: A payload address at or above stop·256 is reduced by (stop−start)·256, so that every write falls inside the ring.
- R10: On the edge of the last header write, `cur_pg` takes the next page and `rx_status` becomes 0x01. Bit 5 (0x20) is also set when bit 0 of the first destination byte is 1. `rx_event` is high for exactly one cycle after that edge.
- R11: Bytes beyond MAX_FRAME (default 1514) are consumed but not stored, and the stored length is capped at MAX_FRAME.
- R12: After reset, `cur_pg` is 0, `rx_status` is 0 and `in_ready` is 1. A pulse on `cfg_cur_wr` loads `cfg_cur_pg` into `cur_pg` at the next edge, but a commit at the same edge takes priority over the load. `in_ready` is low from the cycle after an accepted frame's last byte until the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | Block can take a byte |
| cfg_halt | input | 1 | Receiver stopped; new frames are dropped |
| cfg_promisc | input | 1 | Accept all destinations |
| cfg_take_bcast | input | 1 | Accept broadcast |
| cfg_take_mcast | input | 1 | Accept group addresses |
| cfg_station | input | 48 | Station address; first byte in bits 7:0 |
| cfg_start_pg | input | 8 | First page of the ring |
| cfg_stop_pg | input | 8 | Page just past the ring |
| cfg_bound_pg | input | 8 | Consumer boundary page |
| cfg_cur_wr | input | 1 | Load strobe for the current page |
| cfg_cur_pg | input | 8 | Value to load into the current page |
| cur_pg | output | 8 | Current write page |
| rx_status | output | 8 | Status of the last stored frame |
| rx_event | output | 1 | One-cycle pulse per stored frame |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | 16 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |

## Verification
Two things can happen at the same clock edge: a load of the current page from the configuration side and a frame commit. In the test, an accepted 64-byte frame is sent, and the load strobe is raised with an unrelated page value exactly on the edge of the final header write. The cycle of that edge is counted from the known flush length. The test then checks that `cur_pg` holds the page computed for the frame and not the loaded value, and that the stored bytes still match the model. A second overlap also gets its own directed frame: a payload that crosses the stop page while the next-page arithmetic wraps as well.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [1:0] {
      S_RX   = 2'd0,
      S_DEST = 2'd1,
      S_PAD  = 2'd2,
      S_HDR  = 2'd3
   } rxr_state_e;

   localparam logic [7:0] RSTAT_OK    = 8'h01;
   localparam logic [7:0] RSTAT_GROUP = 8'h20;
   localparam int         HDR_BYTES   = 4;
endpackage

// File: rtl/rxr_dest_filter.sv
module rxr_dest_filter #(
   parameter int AB = 6
) (
   input  logic [8*AB-1:0] dest,
   input  logic [8*AB-1:0] station,
   input  logic            promisc,
   input  logic            take_bcast,
   input  logic            take_mcast,
   output logic            accept
);
   logic [AB-1:0] byte_eq;
   logic [AB-1:0] byte_ones;

   for (genvar gi = 0; gi < AB; gi++) begin : g_byte
      assign byte_eq[gi]   = (dest[8*gi +: 8] == station[8*gi +: 8]);
      assign byte_ones[gi] = &dest[8*gi +: 8];
   end

   logic is_bcast, is_group, is_self;
   assign is_bcast = &byte_ones;
   assign is_group = dest[0];
   assign is_self  = &byte_eq;

   always_comb begin
      if (promisc)       accept = 1'b1;
      else if (is_bcast) accept = take_bcast;
      else if (is_group) accept = take_mcast;
      else               accept = is_self;
   end
endmodule

// File: rtl/rxr_ring_math.sv
module rxr_ring_math #(
   parameter int PG_W      = 8,
   parameter int LEN_W     = 11,
   parameter int MAX_FRAME = 1514,
   parameter int MIN_FRAME = 60
) (
   input  logic [PG_W-1:0]  start_pg,
   input  logic [PG_W-1:0]  stop_pg,
   input  logic [PG_W-1:0]  bound_pg,
   input  logic [PG_W-1:0]  cur,
   input  logic [LEN_W-1:0] len,
   output logic             space_ok,
   output logic [PG_W-1:0]  next_pg,
   output logic [LEN_W-1:0] tot
);
   localparam int SW = PG_W + 9;
   localparam int NW = ((PG_W > LEN_W) ? PG_W : LEN_W) + 2;

   logic [PG_W:0]  free_pg;
   logic [NW-1:0]  span, np;
   logic [LEN_W-1:0] padded;

   // free space in pages, compared as bytes (R5)
   always_comb begin
      if (cur < bound_pg)
         free_pg = {1'b0, bound_pg} - {1'b0, cur};
      else
         free_pg = ({1'b0, stop_pg} - {1'b0, start_pg}) - ({1'b0, cur} - {1'b0, bound_pg});
      space_ok = {free_pg, 8'h00} >= SW'(MAX_FRAME + 4);
   end

   // stored length, header total and next page (R6, R7, R8)
   always_comb begin
      padded  = (len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : len;
      tot     = padded + LEN_W'(4);
      span    = (NW'(tot) + NW'(4 + 255)) >> 8;
      np      = NW'(cur) + span;
      if (np >= NW'(stop_pg))
         np = np - (NW'(stop_pg) - NW'(start_pg));
      next_pg = PG_W'(np);
   end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rxr_pkg::*;
#(
   parameter int PG_W       = 8,
   parameter int MAX_FRAME  = 1514,
   parameter int MIN_FRAME  = 60,
   parameter int ADDR_BYTES = 6,
   localparam int AW        = PG_W + 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [7:0]            in_data,
   input  logic                  in_last,
   output logic                  in_ready,
   input  logic                  cfg_halt,
   input  logic                  cfg_promisc,
   input  logic                  cfg_take_bcast,
   input  logic                  cfg_take_mcast,
   input  logic [8*ADDR_BYTES-1:0] cfg_station,
   input  logic [PG_W-1:0]       cfg_start_pg,
   input  logic [PG_W-1:0]       cfg_stop_pg,
   input  logic [PG_W-1:0]       cfg_bound_pg,
   input  logic                  cfg_cur_wr,
   input  logic [PG_W-1:0]       cfg_cur_pg,
   output logic [PG_W-1:0]       cur_pg,
   output logic [7:0]            rx_status,
   output logic                  rx_event,
   output logic                  mem_we,
   output logic [AW-1:0]         mem_addr,
   output logic [7:0]            mem_wdata
);
   localparam int AB    = ADDR_BYTES;
   localparam int DW    = 8 * AB;
   localparam int LEN_W = $clog2(MAX_FRAME + 9);
   localparam int IW    = (AB > 1) ? $clog2(AB) : 1;
   localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);
   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
   localparam logic [LEN_W-1:0] AB_L  = LEN_W'(AB);

   if (MIN_FRAME < AB || MAX_FRAME < MIN_FRAME) begin : g_bad_len
      $error("rx_ring_writer: need ADDR_BYTES <= MIN_FRAME <= MAX_FRAME");
   end
   if (LEN_W > 16) begin : g_bad_len_w
      $error("rx_ring_writer: header length field holds 16 bits only");
   end
   if (PG_W < 1 || PG_W > 16) begin : g_bad_pg_w
      $error("rx_ring_writer: PG_W out of range");
   end

   rxr_state_e       state;
   logic [LEN_W-1:0] cnt, cnt_nxt, fc, len_r;
   logic [DW-1:0]    dest_r, dest_now;
   logic             keep_r, acc_r, filt_ok, space_ok;
   logic             keep_eff, acc_eff, first, decide;
   logic [PG_W-1:0]  cur_pg_r, next_pg;
   logic [LEN_W-1:0] tot;
   logic [15:0]      tot16;
   logic [7:0]       status_r, status_new;
   logic             event_r;
   logic [7:0]       dest_arr [AB];

   // destination capture: the byte in flight is merged in before the decision
   for (genvar gi = 0; gi < AB; gi++) begin : g_dest
      assign dest_now[8*gi +: 8] = (state == S_RX && in_valid && cnt == LEN_W'(gi))
                                   ? in_data : dest_r[8*gi +: 8];
      assign dest_arr[gi] = dest_r[8*gi +: 8];
   end

   rxr_dest_filter #(.AB(AB)) u_filt (
      .dest       (dest_now),
      .station    (cfg_station),
      .promisc    (cfg_promisc),
      .take_bcast (cfg_take_bcast),
      .take_mcast (cfg_take_mcast),
      .accept     (filt_ok)
   );

   rxr_ring_math #(.PG_W(PG_W), .LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME), .MIN_FRAME(MIN_FRAME)) u_math (
      .start_pg (cfg_start_pg),
      .stop_pg  (cfg_stop_pg),
      .bound_pg (cfg_bound_pg),
      .cur      (cur_pg_r),
      .len      (len_r),
      .space_ok (space_ok),
      .next_pg  (next_pg),
      .tot      (tot)
   );

   assign first      = (cnt == '0);
   assign decide     = (cnt == AB_L - LEN_W'(1)) || (in_last && cnt < AB_L);
   assign keep_eff   = first ? (!cfg_halt && space_ok) : keep_r;
   assign acc_eff    = (cnt < AB_L) ? filt_ok : acc_r;
   assign cnt_nxt    = (cnt == MAX_L) ? cnt : cnt + LEN_W'(1);
   assign tot16      = 16'(tot);
   assign status_new = RSTAT_OK | (dest_r[0] ? RSTAT_GROUP : 8'h00);

   // payload byte address with wrap from stop back to start (R9)
   function automatic logic [AW-1:0] ring_addr(input logic [PG_W-1:0] pg,
                                               input logic [LEN_W-1:0] off);
      logic [AW:0] a;
      a = {1'b0, pg, 8'h00} + (AW+1)'(off) + (AW+1)'(HDR_BYTES);
      if (a >= {1'b0, cfg_stop_pg, 8'h00})
         a = a - {1'b0, cfg_stop_pg - cfg_start_pg, 8'h00};
      return AW'(a);
   endfunction

   always_comb begin
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = 8'h00;
      case (state)
         S_RX: if (in_valid && keep_eff && acc_eff && cnt >= AB_L && cnt < MAX_L) begin
            mem_we    = 1'b1;
            mem_addr  = ring_addr(cur_pg_r, cnt);
            mem_wdata = in_data;
         end
         S_DEST: begin
            mem_we    = 1'b1;
            mem_addr  = ring_addr(cur_pg_r, fc);
            mem_wdata = dest_arr[IW'(fc)];
         end
         S_PAD: begin
            mem_we    = 1'b1;
            mem_addr  = ring_addr(cur_pg_r, fc);
         end
         S_HDR: begin
            mem_we    = 1'b1;
            mem_addr  = {cur_pg_r, 6'b0, fc[1:0]};
            case (fc[1:0])
               2'd0:    mem_wdata = status_new;
               2'd1:    mem_wdata = 8'(next_pg);
               2'd2:    mem_wdata = tot16[7:0];
               default: mem_wdata = tot16[15:8];
            endcase
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_RX;
         cnt      <= '0;
         fc       <= '0;
         len_r    <= '0;
         dest_r   <= '0;
         keep_r   <= 1'b0;
         acc_r    <= 1'b0;
         cur_pg_r <= '0;
         status_r <= 8'h00;
         event_r  <= 1'b0;
      end else begin
         event_r <= 1'b0;
         if (cfg_cur_wr) cur_pg_r <= cfg_cur_pg;
         case (state)
            S_RX: if (in_valid) begin
               cnt    <= cnt_nxt;
               dest_r <= dest_now;
               if (first)  keep_r <= keep_eff;
               if (decide) acc_r  <= filt_ok;
               if (in_last) begin
                  cnt   <= '0;
                  fc    <= '0;
                  len_r <= cnt_nxt;
                  if (keep_eff && acc_eff) begin
                     state <= S_DEST;
                  end else begin
                     dest_r <= '0;
                     keep_r <= 1'b0;
                     acc_r  <= 1'b0;
                  end
               end
            end
            S_DEST: begin
               fc <= fc + LEN_W'(1);
               if (fc == AB_L - LEN_W'(1)) begin
                  if (len_r < MIN_L) begin
                     state <= S_PAD;
                     fc    <= (len_r > AB_L) ? len_r : AB_L;
                  end else begin
                     state <= S_HDR;
                     fc    <= '0;
                  end
               end
            end
            S_PAD: begin
               fc <= fc + LEN_W'(1);
               if (fc == MIN_L - LEN_W'(1)) begin
                  state <= S_HDR;
                  fc    <= '0;
               end
            end
            S_HDR: begin
               fc <= fc + LEN_W'(1);
               if (fc == LEN_W'(HDR_BYTES - 1)) begin
                  state    <= S_RX;
                  fc       <= '0;
                  cur_pg_r <= next_pg;   // commit overrides a load (R12)
                  status_r <= status_new;
                  event_r  <= 1'b1;
                  dest_r   <= '0;
                  keep_r   <= 1'b0;
                  acc_r    <= 1'b0;
               end
            end
            default: state <= S_RX;
         endcase
      end
   end

   assign in_ready  = (state == S_RX);
   assign cur_pg    = cur_pg_r;
   assign rx_status = status_r;
   assign rx_event  = event_r;

   // every buffer write stays inside the ring (R9)
   p_wr_in_ring_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr >= {cfg_start_pg, 8'h00} && mem_addr < {cfg_stop_pg, 8'h00}));

   // the event is a single-cycle pulse (R10)
   p_evt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event |=> !rx_event);

   // a stored frame always reports received-ok (R10)
   p_evt_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event |-> rx_status[0]);

   // the commit follows a header write in the previous cycle (R7)
   p_hdr_before_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event |-> $past(mem_we));

   // after a commit the current page lies inside the ring (R8)
   p_cur_in_ring_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_event |-> (cur_pg >= cfg_start_pg && cur_pg < cfg_stop_pg));

   // a stopped receiver writes nothing for a frame starting now (R4)
   p_halt_no_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RX && in_valid && first && cfg_halt) |-> !mem_we);
endmodule

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
   localparam int MAXF  = 1514;
   localparam int START = 8'h40;
   localparam int STOP  = 8'h50;
   localparam int RING  = (STOP - START) * 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_last = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready;
   logic        cfg_halt = 1'b0, cfg_promisc = 1'b0, cfg_take_bcast = 1'b0, cfg_take_mcast = 1'b0;
   logic [47:0] cfg_station = 48'h56_34_12_00_54_52;
   logic [7:0]  cfg_start_pg = 8'(START), cfg_stop_pg = 8'(STOP), cfg_bound_pg = 8'(START);
   logic        cfg_cur_wr = 1'b0;
   logic [7:0]  cfg_cur_pg = 8'h00;
   logic [7:0]  cur_pg, rx_status, mem_wdata;
   logic        rx_event, mem_we;
   logic [15:0] mem_addr;

   rx_ring_writer dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
      .in_ready(in_ready), .cfg_halt(cfg_halt), .cfg_promisc(cfg_promisc),
      .cfg_take_bcast(cfg_take_bcast), .cfg_take_mcast(cfg_take_mcast), .cfg_station(cfg_station),
      .cfg_start_pg(cfg_start_pg), .cfg_stop_pg(cfg_stop_pg), .cfg_bound_pg(cfg_bound_pg),
      .cfg_cur_wr(cfg_cur_wr), .cfg_cur_pg(cfg_cur_pg), .cur_pg(cur_pg), .rx_status(rx_status),
      .rx_event(rx_event), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

   always #10 clk = ~clk;   // 50 MHz

   int total = 0, bad = 0;
   int wr_cnt = 0, ev_cnt = 0, out_cnt = 0;
   logic [7:0] act_mem [RING];
   logic [7:0] exp_mem [RING];
   logic [7:0] fb [1600];
   int exp_cur;
   int exp_stat = 0;
   int last_tot, last_next;

   always @(negedge clk) begin
      if (mem_we) begin
         wr_cnt++;
         if (int'(mem_addr) < START * 256 || int'(mem_addr) >= STOP * 256) out_cnt++;
         else act_mem[int'(mem_addr) - START * 256] = mem_wdata;
      end
      if (rx_event) ev_cnt++;
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   function automatic int raddr(input int pg, input int k);
      int a;
      a = pg * 256 + 4 + k;
      if (a >= STOP * 256) a -= RING;
      return a;
   endfunction

   // model of filter, space test and storage; returns 1 if frame is stored
   function automatic bit model(input int n);
      int d [6];
      int free_b, L, P, nx;
      bit bc, acc;
      for (int i = 0; i < 6; i++) d[i] = (i < n) ? int'(fb[i]) : 0;
      if (exp_cur < int'(cfg_bound_pg)) free_b = (int'(cfg_bound_pg) - exp_cur) * 256;
      else free_b = ((STOP - START) - (exp_cur - int'(cfg_bound_pg))) * 256;
      if (cfg_halt || free_b < MAXF + 4) return 1'b0;
      bc = 1'b1;
      for (int i = 0; i < 6; i++) if (d[i] != 255) bc = 1'b0;
      if (cfg_promisc) acc = 1'b1;
      else if (bc) acc = cfg_take_bcast;
      else if (d[0] % 2 == 1) acc = cfg_take_mcast;
      else begin
         acc = 1'b1;
         for (int i = 0; i < 6; i++) if (d[i] != int'(cfg_station[8*i +: 8])) acc = 1'b0;
      end
      if (!acc) return 1'b0;
      L = (n > MAXF) ? MAXF : n;
      P = (L < 60) ? 60 : L;
      last_tot = P + 4;
      nx = exp_cur + (last_tot + 4 + 255) / 256;
      if (nx >= STOP) nx -= (STOP - START);
      last_next = nx;
      for (int k = 0; k < P; k++)
         exp_mem[raddr(exp_cur, k) - START * 256] = (k < L) ? fb[k] : 8'h00;
      exp_stat = 1 | ((d[0] % 2 == 1) ? 32 : 0);
      exp_mem[exp_cur * 256 - START * 256 + 0] = 8'(exp_stat);
      exp_mem[exp_cur * 256 - START * 256 + 1] = 8'(nx);
      exp_mem[exp_cur * 256 - START * 256 + 2] = 8'(last_tot);
      exp_mem[exp_cur * 256 - START * 256 + 3] = 8'(last_tot >> 8);
      exp_cur = nx;
      return 1'b1;
   endfunction

   function automatic int mem_diff();
      int m = 0;
      for (int i = 0; i < RING; i++) if (act_mem[i] !== exp_mem[i]) m++;
      return m;
   endfunction

   // dtype: 0 station, 1 broadcast, 2 group, 3 other unicast
   task automatic build(input int dtype, input int n);
      for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
      for (int i = 0; i < 6; i++) begin
         case (dtype)
            0: fb[i] = cfg_station[8*i +: 8];
            1: fb[i] = 8'hFF;
            2: fb[i] = (i == 0) ? (8'($urandom) | 8'h01) : ((i == 1) ? 8'h00 : 8'($urandom));
            default: fb[i] = (i == 5) ? (cfg_station[47:40] ^ 8'h01) : cfg_station[8*i +: 8];
         endcase
      end
   endtask

   task automatic send(input int n);
      for (int i = 0; i < n; i++) begin
         while (!in_ready) @(negedge clk);
         in_valid = 1'b1;
         in_data  = fb[i];
         in_last  = (i == n - 1);
         @(negedge clk);
         in_valid = 1'b0;
         in_last  = 1'b0;
      end
   endtask

   task automatic run(input int n, input string req);
      int w0, e0, c0, tmo;
      bit stored;
      w0 = wr_cnt; e0 = ev_cnt; c0 = exp_cur;
      stored = model(n);
      send(n);
      if (stored) begin
         check(in_ready == 1'b0, {req, " R12 ready low in flush"}, int'(in_ready), 0);
         tmo = 0;
         while (ev_cnt == e0 && tmo < 4000) begin @(negedge clk); #1; tmo++; end
         check(ev_cnt == e0 + 1, {req, " R10 event"}, ev_cnt - e0, 1);
         check(int'(cur_pg) == exp_cur, {req, " R8 next page"}, int'(cur_pg), exp_cur);
         check(int'(rx_status) == exp_stat, {req, " R10 status"}, int'(rx_status), exp_stat);
         check(mem_diff() == 0, {req, " R7 ring contents"}, mem_diff(), 0);
      end else begin
         repeat (4) @(negedge clk);
         #1;
         check(wr_cnt == w0 && ev_cnt == e0, {req, " R3 dropped frame silent"}, wr_cnt - w0, 0);
         check(int'(cur_pg) == c0, {req, " R3 page kept"}, int'(cur_pg), c0);
      end
      check(out_cnt == 0, {req, " R9 writes in ring"}, out_cnt, 0);
      cfg_bound_pg = 8'(exp_cur);
   endtask

   task automatic load_cur(input int pg);
      cfg_cur_pg = 8'(pg);
      cfg_cur_wr = 1'b1;
      @(negedge clk);
      cfg_cur_wr = 1'b0;
      exp_cur = pg;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed, e0, np;
      seed = int'($urandom(32'h1F2E3D));
      for (int i = 0; i < RING; i++) begin act_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
      exp_cur = 0;
      repeat (3) @(negedge clk);
      #1;
      check(in_ready == 1'b1, "R12 reset ready", int'(in_ready), 1);
      check(cur_pg == 8'h00, "R12 reset page", int'(cur_pg), 0);
      check(rx_status == 8'h00 && !rx_event && !mem_we, "R12 reset status", int'(rx_status), 0);
      rst_n = 1'b1;
      @(negedge clk);
      load_cur(START);
      #1;
      check(int'(cur_pg) == START, "R12 page load", int'(cur_pg), START);
      cfg_bound_pg = 8'(START);

      build(0, 64);  run(64, "R3 station frame");
      build(3, 64);  run(64, "R3 foreign unicast");
      cfg_promisc = 1'b1;
      build(3, 80);  run(80, "R1 promisc foreign");
      cfg_promisc = 1'b0;
      build(1, 70);  run(70, "R2 bcast disabled");
      cfg_take_bcast = 1'b1;
      build(1, 70);  run(70, "R2 bcast enabled");
      build(2, 90);  run(90, "R2 group disabled");
      cfg_take_mcast = 1'b1;
      build(2, 90);  run(90, "R2 group enabled, R10 group bit");
      build(0, 20);  run(20, "R6 short padded");
      cfg_promisc = 1'b1;
      build(3, 3);   run(3, "R6 tiny frame");
      cfg_promisc = 1'b0;
      cfg_halt = 1'b1;
      build(0, 64);  run(64, "R4 halted");
      cfg_halt = 1'b0;
      cfg_bound_pg = 8'(exp_cur + 3);
      build(0, 64);  run(64, "R5 no space");
      cfg_bound_pg = 8'(exp_cur);
      load_cur(8'h4E);
      cfg_bound_pg = 8'h4E;
      build(0, 700); run(700, "R9 payload wrap");
      build(0, 1530); run(1530, "R11 oversize capped");

      // load and commit on the same edge: commit must win (R12)
      build(0, 64);
      e0 = ev_cnt;
      void'(model(64));
      np = exp_cur;
      send(64);
      repeat (9) @(negedge clk);
      cfg_cur_pg = 8'h47;
      cfg_cur_wr = 1'b1;
      @(negedge clk);
      cfg_cur_wr = 1'b0;
      #1;
      check(ev_cnt == e0 + 1, "R12 collide event", ev_cnt - e0, 1);
      check(int'(cur_pg) == np, "R12 commit beats load", int'(cur_pg), np);
      check(mem_diff() == 0, "R12 collide contents", mem_diff(), 0);
      cfg_bound_pg = 8'(exp_cur);

      for (int f = 0; f < 40; f++) begin
         int n, ty;
         ty = int'($urandom % 4);
         n  = (f % 13 == 7) ? 1500 : 1 + int'($urandom % 300);
         cfg_promisc    = ($urandom % 5) == 0;
         cfg_take_bcast = $urandom % 2;
         cfg_take_mcast = $urandom % 2;
         build(ty, n);
         run(n, "R1 R2 R3 random frame");
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule